// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block is the coherence engine for one private write-back cache that shares an atomic snooping bus with its peers. It keeps a state for every block in a small array. It accepts load, store and eviction requests from the processor one at a time. Requests that need the bus are raised through a request/grant handshake. The controller also watches every transaction that other caches put on the bus. Hits and silent evictions finish locally. Misses, upgrades and dirty evictions wait in a transient state until the grant, because grants can arrive many cycles after the request. While a block waits, snooped traffic can still downgrade it or take it away.

Snooped transactions come from other caches. When this cache holds a block dirty, it signals that it supplies that block's data. Writes are handled by invalidation, so a snooped request for a writable copy removes every local copy. A write-back from a pending eviction that a snoop has overtaken is dropped, because the data already left through the snoop reply.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every block is Invalid, `bus_req`, `cpu_done` and `snp_supply` are low, and `cpu_ready` is high whenever no snoop addresses `cpu_blk`.
- R2: Operation codes are 0 = load, 1 = store, 2 or 3 = evict. A load to a Shared or Modified block and a store to a Modified block complete locally: `cpu_done` pulses in the cycle after acceptance, `cpu_fetched` and `cpu_wrote_back` are 0, and `bus_req` stays low.
- R3: Bus command codes are 0 = GetS, 1 = GetM, 2 = PutM. A load to an Invalid block requests GetS, and a store to an Invalid or Shared block requests GetM. `bus_req` rises in the cycle after acceptance and stays high until the cycle of `bus_gnt`. `bus_cmd` and `bus_blk` stay constant throughout.
- R4: `cpu_done` pulses in the cycle after the grant. `cpu_fetched` is 1 when the block held no valid copy at grant time, so a Data reply was needed. It is 0 for a clean Shared-to-Modified upgrade. After a granted GetS the block is Shared, and after a granted GetM it is Modified.
- R5: A snooped GetS to a Modified block pulses `snp_supply` in the next cycle and leaves the block Shared. A later store to it then requests GetM.
- R6: A snooped GetM pulses `snp_supply` next cycle if the block was Modified. It makes a Shared or Modified block Invalid, and a Shared block supplies nothing.
- R7: If a snooped GetM to the same block arrives while a Shared-to-Modified upgrade waits, the block becomes Invalid-pending. The later grant then reports `cpu_fetched` = 1.
- R8: Evicting a Modified block requests PutM and completes after the grant with `cpu_wrote_back` = 1, leaving it Invalid. Evicting a Shared or Invalid block is silent: it completes next cycle without the bus and leaves the block Invalid.
- R9: A snooped GetS or GetM to a block whose PutM is waiting pulses `snp_supply`, withdraws `bus_req`, and completes the eviction in the next cycle with `cpu_wrote_back` = 0.
- R10: `cpu_ready` is low in any cycle where a snoop addresses `cpu_blk`. A snooped PutM changes no state and supplies nothing. `bus_gnt` and `snp_valid` are never high together.
- R11: Only one request is outstanding. `cpu_ready` is low from acceptance until the cycle after `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Operation: 0 load, 1 store, 2/3 evict |
| cpu_blk | input | IDX_W | Block index of the request |
| cpu_ready | output | 1 | Request accepted this cycle if valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_fetched | output | 1 | Completion needed a Data reply |
| cpu_wrote_back | output | 1 | Completion wrote dirty data with PutM |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_cmd | output | 2 | Requested command: 0 GetS, 1 GetM, 2 PutM |
| bus_blk | output | IDX_W | Block of the requested transaction |
| bus_gnt | input | 1 | Grant; own transaction occupies the bus this cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command: 0 GetS, 1 GetM, 2 PutM |
| snp_blk | input | IDX_W | Snooped block index |
| snp_supply | output | 1 | This cache supplies data for last cycle's snoop |

## Verification
Two events can fall in the same cycle. A snoop from another cache can arrive while the processor presents a request for the same block. A snoop can also arrive while this cache waits for its own grant on that block. The bench provokes the first by holding a load on a block while a snoop addresses it, and expects `cpu_ready` low until the snoop has passed. It provokes the second by snooping GetM during a pending upgrade and GetS during a pending PutM. For those it judges `cpu_fetched` at the later grant, or the withdrawn request and `cpu_wrote_back` = 0, against a behavioural model that is compared every cycle.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [2:0] {
      LS_INV  = 3'd0,
      LS_SHR  = 3'd1,
      LS_MOD  = 3'd2,
      LS_IS_W = 3'd3,   // invalid, waiting for readable copy
      LS_IM_W = 3'd4,   // invalid, waiting for writable copy
      LS_SM_W = 3'd5,   // shared, waiting for upgrade
      LS_MI_W = 3'd6    // modified, waiting to write back
   } line_st_t;

   localparam logic [1:0] CMD_GETS = 2'd0;
   localparam logic [1:0] CMD_GETM = 2'd1;
   localparam logic [1:0] CMD_PUTM = 2'd2;

   localparam logic [1:0] OP_LOAD  = 2'd0;
   localparam logic [1:0] OP_STORE = 2'd1;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIT  = 2'd1,
      PH_WAIT = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

   function automatic logic is_waiting(line_st_t s);
      return (s == LS_IS_W) || (s == LS_IM_W) || (s == LS_SM_W) || (s == LS_MI_W);
   endfunction
endpackage

// File: rtl/msi_line_fsm.sv
module msi_line_fsm
   import msi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_here,
   input  logic [1:0] acc_op,
   input  logic       gnt_here,
   input  logic       snp_here,
   input  logic [1:0] snp_cmd,
   output line_st_t   state,
   output logic       supply
);
   line_st_t nxt;
   logic     dirty_hit;

   assign dirty_hit = snp_here && (snp_cmd != CMD_PUTM) &&
                      ((state == LS_MOD) || (state == LS_MI_W));

   always_comb begin
      nxt = state;
      if (gnt_here) begin
         unique case (state)
            LS_IS_W:          nxt = LS_SHR;
            LS_IM_W, LS_SM_W: nxt = LS_MOD;
            LS_MI_W:          nxt = LS_INV;
            default:          nxt = state;
         endcase
      end else if (snp_here) begin
         if (snp_cmd == CMD_GETS) begin
            if (state == LS_MOD)       nxt = LS_SHR;
            else if (state == LS_MI_W) nxt = LS_INV;
         end else if (snp_cmd == CMD_GETM) begin
            if ((state == LS_SHR) || (state == LS_MOD) || (state == LS_MI_W))
               nxt = LS_INV;
            else if (state == LS_SM_W)
               nxt = LS_IM_W;
         end
      end else if (acc_here) begin
         unique case (state)
            LS_INV: begin
               if (acc_op == OP_LOAD)       nxt = LS_IS_W;
               else if (acc_op == OP_STORE) nxt = LS_IM_W;
            end
            LS_SHR: begin
               if (acc_op == OP_STORE)      nxt = LS_SM_W;
               else if (acc_op[1])          nxt = LS_INV;
            end
            LS_MOD: begin
               if (acc_op[1])               nxt = LS_MI_W;
            end
            default: nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= LS_INV;
         supply <= 1'b0;
      end else begin
         state  <= nxt;
         supply <= dirty_hit;
      end
   end

   // R6
   inval_on_getm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_here && !gnt_here && snp_cmd == CMD_GETM && !is_waiting(state))
      |=> (state == LS_INV));

   // R5
   downgrade_on_gets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_here && !gnt_here && snp_cmd == CMD_GETS && state == LS_MOD)
      |=> (state == LS_SHR));

   // R10
   putm_snoop_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_here && !gnt_here && !acc_here && snp_cmd == CMD_PUTM)
      |=> $stable(state));
endmodule

// File: rtl/msi_txn_tracker.sv
module msi_txn_tracker
   import msi_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             acc_miss,
   input  logic [1:0]       acc_cmd,
   input  logic [IDX_W-1:0] acc_blk,
   input  logic             gnt,
   input  logic             gnt_fetch,
   input  logic             gnt_wb,
   input  logic             kill,
   output logic             idle,
   output logic             req,
   output logic [1:0]       req_cmd,
   output logic [IDX_W-1:0] req_blk,
   output logic             done,
   output logic             fetched,
   output logic             wrote_back
);
   phase_t phase;

   assign idle = (phase == PH_IDLE);
   assign req  = (phase == PH_WAIT);
   assign done = (phase == PH_HIT) || (phase == PH_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         req_cmd    <= CMD_GETS;
         req_blk    <= '0;
         fetched    <= 1'b0;
         wrote_back <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: if (acc) begin
               phase      <= acc_miss ? PH_WAIT : PH_HIT;
               req_cmd    <= acc_cmd;
               req_blk    <= acc_blk;
               fetched    <= 1'b0;
               wrote_back <= 1'b0;
            end
            PH_WAIT: if (gnt) begin
               phase      <= PH_DONE;
               fetched    <= gnt_fetch;
               wrote_back <= gnt_wb;
            end else if (kill) begin
               phase      <= PH_DONE;
               fetched    <= 1'b0;
               wrote_back <= 1'b0;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !gnt) |=> (!req || ($stable(req_cmd) && $stable(req_blk))));

   // R4
   done_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && gnt) |=> (done && !req));
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int NUM_BLOCKS = 8,
   localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic [1:0]       cpu_op,
   input  logic [IDX_W-1:0] cpu_blk,
   output logic             cpu_ready,
   output logic             cpu_done,
   output logic             cpu_fetched,
   output logic             cpu_wrote_back,
   output logic             bus_req,
   output logic [1:0]       bus_cmd,
   output logic [IDX_W-1:0] bus_blk,
   input  logic             bus_gnt,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [IDX_W-1:0] snp_blk,
   output logic             snp_supply
);
   if (NUM_BLOCKS < 2) begin : g_bad_count
      $error("NUM_BLOCKS must be at least 2");
   end
   if ((1 << IDX_W) != NUM_BLOCKS) begin : g_bad_pow2
      $error("NUM_BLOCKS must be a power of two");
   end

   line_st_t               st_vec [NUM_BLOCKS];
   logic [NUM_BLOCKS-1:0]  sup_vec;
   logic [NUM_BLOCKS-1:0]  wait_vec;
   line_st_t               sel_st, bus_st;
   logic                   idle, acc, collide, acc_miss, gnt_eff, kill;
   logic [1:0]             acc_cmd;

   assign sel_st    = st_vec[cpu_blk];
   assign bus_st    = st_vec[bus_blk];
   assign collide   = snp_valid && (snp_blk == cpu_blk);
   assign cpu_ready = idle && !collide;
   assign acc       = cpu_valid && cpu_ready;
   assign gnt_eff   = bus_req && bus_gnt;
   assign kill      = bus_req && snp_valid && (snp_blk == bus_blk) &&
                      (bus_st == LS_MI_W) && (snp_cmd != CMD_PUTM);

   always_comb begin
      acc_miss = 1'b0;
      acc_cmd  = CMD_GETS;
      unique case (sel_st)
         LS_INV: if (!cpu_op[1]) begin
            acc_miss = 1'b1;
            acc_cmd  = (cpu_op == OP_STORE) ? CMD_GETM : CMD_GETS;
         end
         LS_SHR: if (cpu_op == OP_STORE) begin
            acc_miss = 1'b1;
            acc_cmd  = CMD_GETM;
         end
         LS_MOD: if (cpu_op[1]) begin
            acc_miss = 1'b1;
            acc_cmd  = CMD_PUTM;
         end
         default: ;
      endcase
   end

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_line
      msi_line_fsm u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .acc_here (acc && (cpu_blk == IDX_W'(i))),
         .acc_op   (cpu_op),
         .gnt_here (gnt_eff && (bus_blk == IDX_W'(i))),
         .snp_here (snp_valid && (snp_blk == IDX_W'(i))),
         .snp_cmd  (snp_cmd),
         .state    (st_vec[i]),
         .supply   (sup_vec[i])
      );
      assign wait_vec[i] = is_waiting(st_vec[i]);
   end

   assign snp_supply = |sup_vec;

   msi_txn_tracker #(.IDX_W(IDX_W)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .acc_miss   (acc_miss),
      .acc_cmd    (acc_cmd),
      .acc_blk    (cpu_blk),
      .gnt        (gnt_eff),
      .gnt_fetch  ((bus_st == LS_IS_W) || (bus_st == LS_IM_W)),
      .gnt_wb     (bus_st == LS_MI_W),
      .kill       (kill),
      .idle       (idle),
      .req        (bus_req),
      .req_cmd    (bus_cmd),
      .req_blk    (bus_blk),
      .done       (cpu_done),
      .fetched    (cpu_fetched),
      .wrote_back (cpu_wrote_back)
   );

   // R11
   one_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wait_vec) <= 1);

   // R10
   gnt_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_gnt && snp_valid));

   // R5
   supply_after_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> $past(snp_valid));

   // R9
   withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!bus_req && cpu_done && !cpu_wrote_back));
endmodule

// File: tb/sim_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_msi_snoop_ctrl;
   localparam int NB = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [1:0]    cpu_op = 2'd0;
   logic [IW-1:0] cpu_blk = '0;
   logic          cpu_ready, cpu_done, cpu_fetched, cpu_wrote_back;
   logic          bus_req;
   logic [1:0]    bus_cmd;
   logic [IW-1:0] bus_blk;
   logic          bus_gnt = 1'b0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [IW-1:0] snp_blk = '0;
   logic          snp_supply;

   always #2.5 clk = ~clk;

   msi_snoop_ctrl #(.NUM_BLOCKS(NB)) u0 (.*);

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   // model: block codes 0 I,1 S,2 M,3 I->S,4 I->M,5 S->M,6 M->I ; phase 0 idle,1 hit,2 wait,3 done
   int m_st [NB];
   int m_ph = 0;
   int m_bb = 0;
   int m_bc = 0;
   bit e_fet = 0, e_wb = 0, e_sup = 0;

   task automatic chk(string tag, string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(string tag, bit cv, logic [1:0] op, int blk, bit g, bit sv,
                       logic [1:0] sc, int sb);
      bit rdy, acc;
      int ph, s;
      cpu_valid = cv; cpu_op = op; cpu_blk = IW'(blk);
      bus_gnt = g; snp_valid = sv; snp_cmd = sc; snp_blk = IW'(sb);
      #1;
      rdy = (m_ph == 0) && !(sv && sb == blk);
      chk(tag, "cpu_ready", cpu_ready, rdy);
      acc = cv && rdy;
      @(posedge clk);
      ph = m_ph;
      e_sup = 0;
      if (g && ph == 2) begin
         e_fet = (m_st[m_bb] == 3) || (m_st[m_bb] == 4);
         e_wb  = (m_st[m_bb] == 6);
         m_st[m_bb] = (m_st[m_bb] == 3) ? 1 : (m_st[m_bb] == 6) ? 0 : 2;
         m_ph = 3;
      end else if (sv) begin
         if (sc != 2 && (m_st[sb] == 2 || m_st[sb] == 6)) e_sup = 1;
         if (ph == 2 && sb == m_bb && m_st[sb] == 6 && sc != 2) begin
            m_ph = 3; e_fet = 0; e_wb = 0;
         end
         if (sc == 0) begin
            if (m_st[sb] == 2) m_st[sb] = 1;
            else if (m_st[sb] == 6) m_st[sb] = 0;
         end else if (sc == 1) begin
            if (m_st[sb] == 1 || m_st[sb] == 2 || m_st[sb] == 6) m_st[sb] = 0;
            else if (m_st[sb] == 5) m_st[sb] = 4;
         end
      end
      if (ph == 1 || ph == 3) m_ph = 0;
      if (acc) begin
         s = m_st[blk];
         e_fet = 0; e_wb = 0;
         if (s == 0 && !op[1]) begin
            m_ph = 2; m_bb = blk; m_bc = (op == 1) ? 1 : 0; m_st[blk] = (op == 1) ? 4 : 3;
         end else if (s == 1 && op == 1) begin
            m_ph = 2; m_bb = blk; m_bc = 1; m_st[blk] = 5;
         end else if (s == 2 && op[1]) begin
            m_ph = 2; m_bb = blk; m_bc = 2; m_st[blk] = 6;
         end else begin
            m_ph = 1;
            if (s == 1 && op[1]) m_st[blk] = 0;
         end
      end
      @(negedge clk);
      chk(tag, "cpu_done", cpu_done, (m_ph == 1 || m_ph == 3));
      chk(tag, "bus_req", bus_req, (m_ph == 2));
      chk(tag, "snp_supply", snp_supply, e_sup);
      if (m_ph == 2) begin
         chk(tag, "bus_cmd", bus_cmd, m_bc);
         chk(tag, "bus_blk", bus_blk, m_bb);
      end
      if (m_ph == 1 || m_ph == 3) begin
         chk(tag, "cpu_fetched", cpu_fetched, e_fet);
         chk(tag, "cpu_wrote_back", cpu_wrote_back, e_wb);
      end
   endtask

   task automatic idle_n(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_op(string tag, logic [1:0] op, int blk, int dly,
                        bit se, logic [1:0] sc, int sb);
      bit was_idle;
      do begin
         was_idle = (m_ph == 0);
         step(tag, 1, op, blk, 0, 0, 0, 0);
      end while (!was_idle);
      idle_n(tag, dly);
      if (se) step(tag, 0, 0, 0, 0, 1, sc, sb);
      if (m_ph == 2) step(tag, 0, 0, 0, 1, 0, 0, 0);
      idle_n(tag, 2);
   endtask

   task automatic snoop(string tag, logic [1:0] sc, int sb);
      step(tag, 0, 0, 0, 0, 1, sc, sb);
      idle_n(tag, 1);
   endtask

   initial begin
      for (int i = 0; i < NB; i++) m_st[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle_n("R1", 3);                       // R1 reset state
      do_op("R3", 0, 1, 3, 0, 0, 0);         // R3 GetS miss, R4 fetched
      do_op("R2", 0, 1, 0, 0, 0, 0);         // R2 load hit in S
      do_op("R4", 1, 1, 2, 0, 0, 0);         // R4 upgrade, fetched 0
      do_op("R2", 1, 1, 0, 0, 0, 0);         // R2 store hit in M
      do_op("R2", 0, 1, 0, 0, 0, 0);
      snoop("R5", 0, 1);                     // R5 supply, downgrade
      do_op("R5", 1, 1, 1, 0, 0, 0);         // R5 store now needs GetM
      snoop("R6", 1, 1);                     // R6 supply, invalidate
      do_op("R6", 0, 1, 0, 0, 0, 0);
      snoop("R6", 1, 1);                     // R6 S->I, no supply
      do_op("R6", 0, 1, 0, 0, 0, 0);
      do_op("R7", 1, 1, 1, 1, 1, 1);         // R7 upgrade race
      do_op("R8", 2, 1, 2, 0, 0, 0);         // R8 PutM
      do_op("R8", 0, 2, 0, 0, 0, 0);
      do_op("R8", 2, 2, 0, 0, 0, 0);         // R8 silent evict
      do_op("R8", 0, 2, 0, 0, 0, 0);         // R8 needs GetS again
      do_op("R9", 1, 3, 0, 0, 0, 0);
      do_op("R9", 2, 3, 1, 1, 0, 3);         // R9 snoop overtakes PutM
      do_op("R9", 0, 3, 0, 0, 0, 0);
      step("R10", 1, 0, 4, 0, 1, 1, 4);      // R10 collision stalls
      step("R10", 1, 0, 4, 0, 1, 0, 4);
      do_op("R10", 0, 4, 0, 0, 0, 0);
      snoop("R10", 2, 4);                    // R10 PutM snoop inert
      do_op("R10", 0, 4, 0, 0, 0, 0);
      step("R11", 1, 1, 5, 0, 0, 0, 0);      // R11 busy while waiting
      step("R11", 1, 1, 6, 0, 0, 0, 0);
      step("R11", 1, 1, 6, 1, 0, 0, 0);
      idle_n("R11", 2);
      for (int i = 0; i < 4000; i++) begin
         bit g, sv;
         g  = (m_ph == 2) && ($urandom % 3 == 0);
         sv = !g && ($urandom % 3 == 0);
         step("MIX", $urandom % 2, 2'($urandom % 4), $urandom % NB, g, sv,
              2'($urandom % 3), $urandom % NB);
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog run did not end");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule